// File: doc/BRIEF.md
# Flash Write-Protection and Status Unit

This block holds the status register of a 1 MiB serial NOR flash and decides whether each program or erase request may go ahead. It tracks a write-enable latch, a busy flag, a three-bit protect code that fences off a region at the top of the address space, and a lock bit that a low write-protect pin turns into a freeze of the protection settings. It sits between the command decoder, which hands it one-cycle strobes, and the array sequencer, which starts work only on a grant.

Each program or erase request gets exactly one answer, grant or reject, in the cycle after the strobe. A grant starts an internal cycle counter that stands in for the array timer. While the counter runs, the busy flag reads 1. When it expires, busy and the write-enable latch drop together. A write-status request that is accepted also runs the counter for its own length. The current status byte is always visible on `status_o`.

Top module: `fwp_status_unit`

## Requirements
- R1: After reset, `status_o` reads 8'h9C: busy 0, write-enable latch 0, protect code 3'b111, lock bit 1.
- R2: The status byte layout is: bit 0 busy, bit 1 write-enable latch, bits 4:2 the protect code (bit 2 its LSB), bits 6:5 zero, bit 7 the lock bit.
- R3: When not busy, `wren_i` sets the write-enable latch and `wrdi_i` clears it.
- R4: A program or erase request is rejected unless the write-enable latch is set. A granted request sets busy in the next cycle.
- R5: The protect code selects how many of the 16 64 KiB blocks, counted down from the top, are protected. The block index is `addr_i[19:16]`. Code 0 protects none, 1 protects block 15, 2 protects blocks 14-15, 3 protects 12-15, 4 protects 8-15, and 5, 6 and 7 protect all blocks. A program, sector erase or block erase whose block is protected is rejected.
- R6: `erase_kind_i` encodes 2'b00 sector, 2'b01 block, and 2'b1x whole chip. A chip erase is granted only when the protect code is 0.
- R7: An accepted write-status request loads the protect code from `wrsr_data_i[4:2]` and the lock bit from `wrsr_data_i[7]`, and holds busy for 3 cycles. The request is accepted only when the write-enable latch is set. Otherwise it has no effect.
- R8: While `wp_n` is low and the lock bit is 1, a write-status request is ignored. The protect code, lock bit and write-enable latch all keep their values.
- R9: Busy lasts exactly 4 cycles for a program, 8 for a sector erase, 12 for a block erase and 16 for a chip erase. When busy falls, the write-enable latch clears in the same cycle.
- R10: While busy, every command strobe leaves the status register unchanged, and program or erase requests are rejected.
- R11: Grant and reject are one-cycle pulses, never both high. One of them follows each program or erase request, and neither appears otherwise.
- R12: When several strobes arrive in one cycle, only the highest-priority one acts, in the order erase, program, write-status, write-disable, write-enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wp_n | input | 1 | Write-protect pin, active low |
| wren_i | input | 1 | Write-enable command strobe |
| wrdi_i | input | 1 | Write-disable command strobe |
| wrsr_i | input | 1 | Write-status command strobe |
| wrsr_data_i | input | 8 | Data byte for write-status |
| prog_i | input | 1 | Program request strobe |
| erase_i | input | 1 | Erase request strobe |
| erase_kind_i | input | 2 | Erase granularity: 00 sector, 01 block, 1x chip |
| addr_i | input | 20 | Target byte address of a program or erase |
| grant_o | output | 1 | Request granted, one-cycle pulse |
| reject_o | output | 1 | Request refused, one-cycle pulse |
| status_o | output | 8 | Current status byte |

## Verification
A wrong latch or protect value shows at the ports no later than the next program or erase request. That request comes back as grant where reject was due, or the other way round, in the cycle after the strobe. A mis-sized busy window shows at once as an early or late fall of status bit 0, and a matching early or late clear of bit 1. A lock that fails to hold shows in the status byte one cycle after the ignored write-status.

// File: rtl/fwp_pkg.sv
package fwp_pkg;
  // decoded operation after strobe priority
  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_WREN  = 3'd1,
    OP_WRDI  = 3'd2,
    OP_WRSR  = 3'd3,
    OP_PROG  = 3'd4,
    OP_ERASE = 3'd5
  } fwp_op_e;

  localparam int PCODE_W = 3;
endpackage

// File: rtl/fwp_region_check.sv
module fwp_region_check #(
  parameter int ADDR_W  = 20,
  parameter int BLOCK_W = 16
) (
  input  logic [fwp_pkg::PCODE_W-1:0] pcode,
  input  logic [ADDR_W-1:0]           addr,
  input  logic                        whole_chip,
  output logic                        hit
);
  localparam int IDX_W      = ADDR_W - BLOCK_W;
  localparam int CW         = IDX_W + 1;
  localparam int NUM_BLOCKS = 1 << IDX_W;
  localparam int FULL_CODE  = 5;   // this code and above cover every block

  logic [CW-1:0] prot_cnt;
  logic [CW-1:0] lo_bound;
  logic [CW-1:0] blk_idx;

  always_comb begin
    if (pcode == '0)
      prot_cnt = '0;
    else if (int'(pcode) < FULL_CODE)
      prot_cnt = CW'(NUM_BLOCKS >> (FULL_CODE - int'(pcode)));
    else
      prot_cnt = CW'(NUM_BLOCKS);
    lo_bound = CW'(NUM_BLOCKS) - prot_cnt;
    blk_idx  = {1'b0, addr[ADDR_W-1:BLOCK_W]};
    if (whole_chip)
      hit = (prot_cnt != '0);
    else
      hit = (prot_cnt != '0) && (blk_idx >= lo_bound);
  end
endmodule

// File: rtl/fwp_busy_timer.sv
module fwp_busy_timer #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] len,
  output logic             busy,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (load)
      cnt_q <= len;
    else if (cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);
  assign done = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/fwp_status_unit.sv
module fwp_status_unit #(
  parameter int ADDR_W   = 20,
  parameter int BLOCK_W  = 16,
  parameter int PROG_CYC = 4,
  parameter int SECT_CYC = 8,
  parameter int BLK_CYC  = 12,
  parameter int CHIP_CYC = 16,
  parameter int WRSR_CYC = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wp_n,
  input  logic              wren_i,
  input  logic              wrdi_i,
  input  logic              wrsr_i,
  input  logic [7:0]        wrsr_data_i,
  input  logic              prog_i,
  input  logic              erase_i,
  input  logic [1:0]        erase_kind_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              grant_o,
  output logic              reject_o,
  output logic [7:0]        status_o
);
  import fwp_pkg::*;

  localparam int MAX_AB  = (PROG_CYC > SECT_CYC) ? PROG_CYC : SECT_CYC;
  localparam int MAX_CD  = (BLK_CYC > CHIP_CYC) ? BLK_CYC : CHIP_CYC;
  localparam int MAX_ABC = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int MAX_CYC = (MAX_ABC > WRSR_CYC) ? MAX_ABC : WRSR_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic               wel_q, bpl_q;
  logic [PCODE_W-1:0] pcode_q;
  fwp_op_e            op;
  logic               busy, done, prot_hit, locked;
  logic               is_req, accept, wrsr_ok, load;
  logic [CNT_W-1:0]   len;

  // strobe priority
  always_comb begin
    if (erase_i)      op = OP_ERASE;
    else if (prog_i)  op = OP_PROG;
    else if (wrsr_i)  op = OP_WRSR;
    else if (wrdi_i)  op = OP_WRDI;
    else if (wren_i)  op = OP_WREN;
    else              op = OP_NONE;
  end

  fwp_region_check #(.ADDR_W(ADDR_W), .BLOCK_W(BLOCK_W)) u_region (
    .pcode      (pcode_q),
    .addr       (addr_i),
    .whole_chip ((op == OP_ERASE) && erase_kind_i[1]),
    .hit        (prot_hit)
  );

  assign locked  = !wp_n && bpl_q;
  assign is_req  = (op == OP_PROG) || (op == OP_ERASE);
  assign accept  = is_req && !busy && wel_q && !prot_hit;
  assign wrsr_ok = (op == OP_WRSR) && !busy && wel_q && !locked;
  assign load    = accept || wrsr_ok;

  always_comb begin
    if (op == OP_PROG)       len = CNT_W'(PROG_CYC);
    else if (op == OP_WRSR)  len = CNT_W'(WRSR_CYC);
    else if (erase_kind_i[1]) len = CNT_W'(CHIP_CYC);
    else if (erase_kind_i[0]) len = CNT_W'(BLK_CYC);
    else                     len = CNT_W'(SECT_CYC);
  end

  fwp_busy_timer #(.CNT_W(CNT_W)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .load (load),
    .len  (len),
    .busy (busy),
    .done (done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wel_q    <= 1'b0;
      pcode_q  <= '1;
      bpl_q    <= 1'b1;
      grant_o  <= 1'b0;
      reject_o <= 1'b0;
    end else begin
      grant_o  <= accept;
      reject_o <= is_req && !accept;
      if (done)
        wel_q <= 1'b0;
      else if (!busy) begin
        if (op == OP_WREN) wel_q <= 1'b1;
        if (op == OP_WRDI) wel_q <= 1'b0;
      end
      if (wrsr_ok) begin
        pcode_q <= wrsr_data_i[4:2];
        bpl_q   <= wrsr_data_i[7];
      end
    end
  end

  assign status_o = {bpl_q, 2'b00, pcode_q, wel_q, busy};
endmodule

// File: rtl/fwp_status_unit_checker.sv
module fwp_status_unit_checker (
  input logic       clk,
  input logic       rst,
  input logic       wp_n,
  input logic       erase_i,
  input logic [1:0] erase_kind_i,
  input logic       grant_o,
  input logic       reject_o,
  input logic [7:0] status_o
);
  p_grant_needs_wel_r4: assert property (@(posedge clk) disable iff (rst)
    grant_o |-> ($past(status_o[1]) && !$past(status_o[0])));

  p_grant_sets_busy_r4: assert property (@(posedge clk) disable iff (rst)
    grant_o |-> status_o[0]);

  p_chip_needs_open_r6: assert property (@(posedge clk) disable iff (rst)
    (grant_o && $past(erase_i && erase_kind_i[1])) |-> ($past(status_o[4:2]) == 3'b000));

  p_lock_holds_r8: assert property (@(posedge clk) disable iff (rst)
    $past(!wp_n && status_o[7]) |-> $stable(status_o[7:2]));

  p_end_clears_wel_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(status_o[0]) |-> !status_o[1]);

  p_busy_freezes_r10: assert property (@(posedge clk) disable iff (rst)
    $past(status_o[0]) |-> $stable(status_o[7:2]));

  p_one_answer_r11: assert property (@(posedge clk) disable iff (rst)
    !(grant_o && reject_o));
endmodule

bind fwp_status_unit fwp_status_unit_checker u_chk (
  .clk          (clk),
  .rst          (rst),
  .wp_n         (wp_n),
  .erase_i      (erase_i),
  .erase_kind_i (erase_kind_i),
  .grant_o      (grant_o),
  .reject_o     (reject_o),
  .status_o     (status_o)
);

// File: tb/fwp_status_unit_tb.sv
module fwp_status_unit_tb;
  logic clk = 1'b0, rst = 1'b1, wp_n = 1'b1;
  logic wren_i = 0, wrdi_i = 0, wrsr_i = 0, prog_i = 0, erase_i = 0;
  logic [7:0]  wrsr_data_i = '0;
  logic [1:0]  erase_kind_i = '0;
  logic [19:0] addr_i = '0;
  logic grant_o, reject_o;
  logic [7:0] status_o;

  int n_checks = 0, n_fail = 0;
  bit finished = 0;

  // bench model state
  logic       m_wel, m_bpl;
  logic [2:0] m_bp;
  int         m_cnt;

  always #4 clk = ~clk;

  fwp_status_unit u_dut (.*);

  task automatic check(string tag, string what, logic [7:0] act, logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
    end
  endtask

  function automatic bit m_prot(logic [2:0] bp, logic [19:0] a, bit chip);
    int n;
    case (bp)
      3'd0: n = 0;
      3'd1: n = 1;
      3'd2: n = 2;
      3'd3: n = 4;
      3'd4: n = 8;
      default: n = 16;
    endcase
    if (chip) return n != 0;
    return int'(a[19:16]) >= 16 - n;
  endfunction

  // one clock: drive, update model, compare
  task automatic cyc(logic en, logic di, logic sr, logic [7:0] d, logic pg,
                     logic er, logic [1:0] k, logic [19:0] a, logic wpn, string tag);
    logic eg, ej, req, chip;
    @(negedge clk);
    wren_i = en; wrdi_i = di; wrsr_i = sr; wrsr_data_i = d; prog_i = pg;
    erase_i = er; erase_kind_i = k; addr_i = a; wp_n = wpn;
    @(posedge clk); #1;
    eg = 0; ej = 0;
    req  = pg || er;
    chip = er && k[1];
    if (m_cnt != 0) begin
      if (req) ej = 1;
      if (m_cnt == 1) m_wel = 0;
      m_cnt--;
    end else if (req) begin
      if (m_wel && !m_prot(m_bp, a, chip)) begin
        eg = 1;
        m_cnt = !er ? 4 : (k[1] ? 16 : (k[0] ? 12 : 8));
      end else ej = 1;
    end else if (sr) begin
      if (m_wel && !(!wpn && m_bpl)) begin
        m_bp = d[4:2]; m_bpl = d[7]; m_cnt = 3;
      end
    end else if (di) m_wel = 0;
    else if (en) m_wel = 1;
    check(tag, "grant", {7'd0, grant_o}, {7'd0, eg});
    check(tag, "reject", {7'd0, reject_o}, {7'd0, ej});
    check(tag, "status", status_o, {m_bpl, 2'b00, m_bp, m_wel, m_cnt != 0});
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) cyc(0,0,0,8'h00,0,0,2'b00,20'h0,wp_n,tag);
  endtask

  initial begin
    int busy_len;
    void'($urandom(32'd7177));
    m_wel = 0; m_bpl = 1; m_bp = 3'b111; m_cnt = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    #1 check("R1", "reset status", status_o, 8'h9C);
    check("R1", "reset grant", {7'd0, grant_o}, 8'h00);
    // R4: no latch -> reject
    cyc(0,0,0,0,1,0,2'b00,20'h00010,1,"R4");
    // R3 set latch, R5 top block protected at code 7
    cyc(1,0,0,0,0,0,2'b00,20'h0,1,"R3");
    cyc(0,0,0,0,1,0,2'b00,20'hF0000,1,"R5");
    // R7 clear protection
    cyc(0,0,1,8'h00,0,0,2'b00,20'h0,1,"R7");
    idle(4, "R7");
    // R2 code 1 at bits 4:2
    cyc(1,0,0,0,0,0,2'b00,20'h0,1,"R3");
    cyc(0,0,1,8'h04,0,0,2'b00,20'h0,1,"R2");
    idle(4, "R2");
    cyc(1,0,0,0,0,0,2'b00,20'h0,1,"R3");
    cyc(0,0,0,0,1,0,2'b00,20'hEFFFF,1,"R5");
    idle(5, "R9");
    cyc(1,0,0,0,0,0,2'b00,20'h0,1,"R3");
    cyc(0,0,0,0,0,1,2'b01,20'hF1234,1,"R5");
    cyc(0,0,0,0,0,1,2'b10,20'h0,1,"R6");
    // R8 lock with pin low
    cyc(0,0,1,8'h9C,0,0,2'b00,20'h0,1,"R7");
    idle(4, "R7");
    cyc(1,0,0,0,0,0,2'b00,20'h0,0,"R3");
    cyc(0,0,1,8'h00,0,0,2'b00,20'h0,0,"R8");
    check("R8", "locked status kept", status_o, 8'h9E);
    cyc(0,0,1,8'h00,0,0,2'b00,20'h0,1,"R7");
    idle(4, "R7");
    // R9 chip erase busy length; R10 commands ignored while busy
    cyc(1,0,0,0,0,0,2'b00,20'h0,1,"R3");
    cyc(0,0,0,0,0,1,2'b11,20'h0,1,"R6");
    busy_len = 1;
    cyc(0,0,1,8'h9C,0,0,2'b00,20'h0,1,"R10");
    busy_len++;
    cyc(0,0,0,0,1,0,2'b00,20'h0,1,"R10");
    busy_len++;
    while (status_o[0] && busy_len < 40) begin
      cyc(0,1,0,0,0,0,2'b00,20'h0,1,"R10");
      if (status_o[0]) busy_len++;
    end
    check("R9", "chip erase busy cycles", 8'(busy_len), 8'd16);
    check("R9", "latch after busy", {7'd0, status_o[1]}, 8'h00);
    // R12 priority
    cyc(1,1,0,0,0,0,2'b00,20'h0,1,"R12");
    cyc(1,0,0,0,0,0,2'b00,20'h0,1,"R3");
    cyc(1,0,0,0,1,1,2'b00,20'h30000,1,"R12");
    // R11 random mix
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] r;
      logic en, di, sr, pg, er;
      r = 8'($urandom_range(0, 255));
      en = r < 60; di = (r >= 60 && r < 75); sr = (r >= 75 && r < 95);
      pg = (r >= 95 && r < 125); er = (r >= 125 && r < 140);
      if (r > 250) begin en = 1; pg = 1; sr = 1; end
      cyc(en, di, sr, 8'($urandom), pg, er, 2'($urandom),
          20'($urandom), ($urandom_range(0, 3) != 0), "R11");
    end
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule